// File: doc/BRIEF.md
# Out-of-band round-robin poll scheduler

This block is the access point side controller of a MAC that uses only contention-free access. It hands the shared radio channel to one station at a time. It does this by raising a short pulse on that station's own line of a one-way control wire. The pulse carries no data; it only grants the station its turn on the channel. After each pulse the scheduler listens to two flags from the radio receiver: the early preamble-detect flag and the frame-decoded flag.

If no preamble shows up within one slot time, the scheduler moves straight on to the next station. If a preamble is seen, it holds off every further poll until the reply has been decoded and its source checked. A reply from the polled station is acknowledged over the radio through a request/done handshake with the transmitter. A frame from any other source counts as interference and gets no acknowledgement. The same applies when no frame arrives before a timeout. In both of those cases the rotation simply continues. The radio mode output stays at receive except while an acknowledgement is being sent.

All durations are counted in clock cycles and set by parameters: the poll pulse width, the slot time (9 µs), and the reply timeout.

Top module: `oob_poll_sched`

## Requirements
- R1: While reset is held and right after it, every poll line is low, `ack_req` and `radio_tx` are 0, and `cur_sta` is 0.
- R2: A poll raises exactly one line of `poll_o`, the one at index `cur_sta`, for exactly `POLL_W` consecutive cycles. No two lines are ever high together.
- R3: Stations are polled in strict order 0, 1, …, `N_STA-1`, then 0 again. `cur_sta` changes only when the rotation advances.
- R4: If `rx_pd` stays low for the `SLOT_CYC` cycles that follow the last high cycle of a poll pulse, the next poll pulse starts after exactly `SLOT_CYC+1` low cycles.
- R5: Once `rx_pd` is seen during the slot, no poll line rises until the reply is resolved, whether as acknowledged, rejected or timed out.
- R6: An `rx_fv` pulse whose `rx_src` equals the polled index (zero-extended) raises `ack_req` on the next cycle. `ack_req` is held until `ack_done`. The next poll starts two cycles after the cycle in which `ack_done` is sampled.
- R7: An `rx_fv` pulse with any other `rx_src` value raises no `ack_req`. The next poll starts two cycles after that frame.
- R8: If no `rx_fv` arrives within `REPLY_TO` cycles after the preamble was taken, no acknowledgement is requested. The next poll starts `REPLY_TO+2` cycles after the preamble cycle.
- R9: `radio_tx` (1 = transmit, 0 = receive) is 1 exactly while `ack_req` is 1.
- R10: With `en` low, the exchange in progress completes and the index still advances, but no new poll is issued. Raising `en` again starts a poll of the current index on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Runs the rotation while high |
| rx_pd | input | 1 | Early preamble-detect flag from the receiver |
| rx_fv | input | 1 | One-cycle pulse: a frame was decoded |
| rx_src | input | SRC_W | Source station ID of the decoded frame |
| ack_done | input | 1 | Transmitter finished sending the acknowledgement |
| poll_o | output | N_STA | One poll line per station |
| ack_req | output | 1 | Request to transmit an acknowledgement |
| radio_tx | output | 1 | Radio mode: 1 transmit, 0 receive |
| cur_sta | output | IDX_W | Index of the station being or about to be polled |

## Verification
A wrong internal state shows up at the ports within a single poll interval. A bad counter makes the pulse width or the idle gap differ from `POLL_W` or `SLOT_CYC+1` at the very next poll. A bad index puts the next pulse on the wrong line or skips the wrap. A bad listen or acknowledge state shows up one cycle after the frame, either as a missing or extra `ack_req`, or as a poll line rising while a reply is still pending. The bench measures each pulse width and gap in cycles and compares them against these counts under idle, good, foreign and silent replies.

// File: rtl/oob_poll_pkg.sv
package oob_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POLL   = 3'd1,
    ST_SLOT   = 3'd2,
    ST_LISTEN = 3'd3,
    ST_ACK    = 3'd4,
    ST_NEXT   = 3'd5
  } sched_st_e;

  // next station in the rotation, wrapping after the last one
  function automatic int rr_next(input int cur, input int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction

  // counter width able to hold the largest of three cycle limits
  function automatic int cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // true on the last cycle of a window of len cycles
  function automatic bit at_last(input int cnt, input int len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/poll_phase_ctr.sv
module poll_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rr_pointer.sv
module rr_pointer #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= IDX_W'(oob_poll_pkg::rr_next(int'(idx), N));
  end

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign mask[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/reply_judge.sv
module reply_judge #(
  parameter int SRC_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             listening,
  input  logic             rx_fv,
  input  logic [SRC_W-1:0] rx_src,
  input  logic [IDX_W-1:0] want,
  output logic             ok,
  output logic             bad
);
  logic src_match;
  assign src_match = (rx_src == SRC_W'(want));
  assign ok  = listening && rx_fv &&  src_match;
  assign bad = listening && rx_fv && !src_match;
endmodule

// File: rtl/oob_poll_sched.sv
module oob_poll_sched #(
  parameter int N_STA    = 4,
  parameter int SRC_W    = 8,
  parameter int POLL_W   = 4,
  parameter int SLOT_CYC = 1125,
  parameter int REPLY_TO = 4000,
  parameter int IDX_W    = (N_STA > 1) ? $clog2(N_STA) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx_pd,
  input  logic             rx_fv,
  input  logic [SRC_W-1:0] rx_src,
  input  logic             ack_done,
  output logic [N_STA-1:0] poll_o,
  output logic             ack_req,
  output logic             radio_tx,
  output logic [IDX_W-1:0] cur_sta
);
  import oob_poll_pkg::*;

  localparam int CNT_W = cnt_width(POLL_W, SLOT_CYC, REPLY_TO);

  sched_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt;
  logic [N_STA-1:0] sta_mask;

  // named events, also observed by the checker
  logic poll_done, pd_seen, slot_expired, listening;
  logic reply_ok, reply_bad, reply_timeout, ack_finish, advance;

  poll_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (st_d != st_q),
    .cnt  (cnt)
  );

  rr_pointer #(.N(N_STA), .IDX_W(IDX_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (advance),
    .idx  (cur_sta),
    .mask (sta_mask)
  );

  assign listening = (st_q == ST_LISTEN);

  reply_judge #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_judge (
    .listening(listening),
    .rx_fv    (rx_fv),
    .rx_src   (rx_src),
    .want     (cur_sta),
    .ok       (reply_ok),
    .bad      (reply_bad)
  );

  assign poll_done     = (st_q == ST_POLL) && at_last(int'(cnt), POLL_W);
  assign pd_seen       = (st_q == ST_SLOT) && rx_pd;
  assign slot_expired  = (st_q == ST_SLOT) && !rx_pd && at_last(int'(cnt), SLOT_CYC);
  assign reply_timeout = listening && !rx_fv && at_last(int'(cnt), REPLY_TO);
  assign ack_finish    = (st_q == ST_ACK) && ack_done;
  assign advance       = (st_q == ST_NEXT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (en) st_d = ST_POLL;
      ST_POLL:   if (poll_done) st_d = ST_SLOT;
      ST_SLOT: begin
        if (pd_seen)           st_d = ST_LISTEN;
        else if (slot_expired) st_d = ST_NEXT;
      end
      ST_LISTEN: begin
        if (reply_ok)                        st_d = ST_ACK;
        else if (reply_bad || reply_timeout) st_d = ST_NEXT;
      end
      ST_ACK:    if (ack_finish) st_d = ST_NEXT;
      ST_NEXT:   st_d = en ? ST_POLL : ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign poll_o   = (st_q == ST_POLL) ? sta_mask : '0;
  assign ack_req  = (st_q == ST_ACK);
  assign radio_tx = (st_q == ST_ACK);

endmodule

// File: rtl/oob_poll_sched_chk.sv
module oob_poll_sched_chk #(
  parameter int N_STA = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_STA-1:0] poll_o,
  input logic             ack_req,
  input logic             ack_done,
  input logic             radio_tx,
  input logic [IDX_W-1:0] cur_sta,
  input logic             advance,
  input logic             listening,
  input logic             reply_ok,
  input logic             reply_bad,
  input logic             slot_expired
);
  // R2
  poll_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(poll_o));

  // R5
  listen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listening |-> (poll_o == '0));

  // R3
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cur_sta == (($past(cur_sta) == IDX_W'(N_STA - 1)) ? '0 : $past(cur_sta) + 1'b1)));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cur_sta));

  // R4
  slot_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_expired |=> advance);

  // R6
  ack_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |=> (ack_req && radio_tx));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_done) |=> ack_req);

  // R7
  no_ack_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_bad |=> !ack_req);

  // R9
  radio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    radio_tx == ack_req);
endmodule

bind oob_poll_sched oob_poll_sched_chk #(.N_STA(N_STA), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .poll_o      (poll_o),
  .ack_req     (ack_req),
  .ack_done    (ack_done),
  .radio_tx    (radio_tx),
  .cur_sta     (cur_sta),
  .advance     (advance),
  .listening   (listening),
  .reply_ok    (reply_ok),
  .reply_bad   (reply_bad),
  .slot_expired(slot_expired)
);

// File: tb/oob_poll_sched_tb.sv
module oob_poll_sched_tb;
  localparam int N        = 4;
  localparam int SRC_W    = 8;
  localparam int POLL_W   = 3;
  localparam int SLOT_CYC = 12;
  localparam int REPLY_TO = 40;
  localparam int IDX_W    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, rx_pd = 1'b0, rx_fv = 1'b0, ack_done = 1'b0;
  logic [SRC_W-1:0] rx_src = '0;
  logic [N-1:0] poll_o;
  logic ack_req, radio_tx;
  logic [IDX_W-1:0] cur_sta;

  int checks = 0, errors = 0, exp_idx = 0;
  bit running = 1'b0, ended = 1'b0;

  always #4 clk = ~clk;

  oob_poll_sched #(.N_STA(N), .SRC_W(SRC_W), .POLL_W(POLL_W),
                   .SLOT_CYC(SLOT_CYC), .REPLY_TO(REPLY_TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_pd(rx_pd), .rx_fv(rx_fv),
    .rx_src(rx_src), .ack_done(ack_done), .poll_o(poll_o),
    .ack_req(ack_req), .radio_tx(radio_tx), .cur_sta(cur_sta));

  function automatic int nxt(input int i);
    return (i + 1) % N;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R9 monitored on every cycle after reset
  always @(negedge clk) begin
    if (running) chk(radio_tx == ack_req, "R9 radio mode", int'(radio_tx), int'(ack_req));
  end

  task automatic count_low(input int limit, output int n);
    n = 0;
    while (poll_o == '0 && n < limit) begin
      n++;
      tick();
    end
  endtask

  task automatic take_poll;
    int n, w, who;
    count_low(100000, n);
    who = -1;
    for (int i = 0; i < N; i++) if (poll_o[i]) who = i;
    chk($countones(poll_o) == 1, "R2 one line", $countones(poll_o), 1);
    chk(who == exp_idx, "R3 order", who, exp_idx);
    chk(int'(cur_sta) == exp_idx, "R3 index", int'(cur_sta), exp_idx);
    w = 0;
    while (poll_o != '0 && w < 1000) begin
      w++;
      tick();
    end
    chk(w == POLL_W, "R2 width", w, POLL_W);
  endtask

  task automatic sc_idle;
    int n;
    count_low(SLOT_CYC + 10, n);
    chk(n == SLOT_CYC + 1, "R4 idle gap", n, SLOT_CYC + 1);
    exp_idx = nxt(exp_idx);
  endtask

  task automatic send_pd(input int d);
    repeat (d) tick();
    rx_pd = 1'b1;
    tick();
    rx_pd = 1'b0;
  endtask

  task automatic sc_good(input int d, input int e, input int h);
    int n;
    send_pd(d);
    repeat (e) begin
      chk(poll_o == '0 && !ack_req, "R5 held", int'(poll_o), 0);
      tick();
    end
    rx_fv = 1'b1; rx_src = SRC_W'(exp_idx);
    tick();
    rx_fv = 1'b0;
    chk(ack_req && radio_tx, "R6 ack raised", int'(ack_req), 1);
    repeat (h) begin
      tick();
      chk(ack_req && poll_o == '0, "R6 ack held", int'(ack_req), 1);
    end
    ack_done = 1'b1;
    tick();
    ack_done = 1'b0;
    chk(!ack_req && !radio_tx, "R9 back to receive", int'(radio_tx), 0);
    count_low(10, n);
    chk(n == 1, "R6 advance gap", n, 1);
    exp_idx = nxt(exp_idx);
  endtask

  task automatic sc_bad(input int d, input int e, input int src);
    int n;
    send_pd(d);
    repeat (e) tick();
    rx_fv = 1'b1; rx_src = SRC_W'(src);
    tick();
    rx_fv = 1'b0;
    chk(!ack_req, "R7 no ack for foreign frame", int'(ack_req), 0);
    count_low(10, n);
    chk(n == 1, "R7 advance gap", n, 1);
    exp_idx = nxt(exp_idx);
  endtask

  task automatic sc_timeout(input int d);
    int n;
    send_pd(d);
    count_low(REPLY_TO + 10, n);
    chk(n == REPLY_TO + 1, "R8 timeout gap", n, REPLY_TO + 1);
    chk(!ack_req, "R8 no ack", int'(ack_req), 0);
    exp_idx = nxt(exp_idx);
  endtask

  task automatic foreign_src(output int src);
    if ($urandom % 3 == 0) src = N + int'($urandom % 200);
    else src = (exp_idx + 1 + int'($urandom % (N - 1))) % N;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, src, seed_set;
    seed_set = $urandom(32'h5EED);
    repeat (3) tick();
    // R1 reset state
    chk(poll_o == '0, "R1 polls low", int'(poll_o), 0);
    chk(!ack_req && !radio_tx, "R1 receive mode", int'(radio_tx), 0);
    chk(cur_sta == '0, "R1 index zero", int'(cur_sta), 0);
    rst_n = 1'b1;
    tick();
    running = 1'b1;
    chk(poll_o == '0 && cur_sta == '0, "R1 after release", int'(poll_o), 0);
    en = 1'b1;

    // full idle rotation with wrap (R3, R4)
    for (int i = 0; i <= N; i++) begin
      take_poll();
      sc_idle();
    end
    // directed corners
    take_poll(); sc_good(0, 0, 0);
    take_poll(); sc_good(SLOT_CYC - 1, REPLY_TO - 1, 3);
    take_poll(); sc_bad(2, 5, (exp_idx + 1) % N);
    take_poll(); sc_bad(0, 0, 255);
    take_poll(); sc_timeout(0);
    take_poll(); sc_timeout(SLOT_CYC - 1);

    // R10 enable drop and resume
    take_poll();
    en = 1'b0;
    count_low(SLOT_CYC + 30, n);
    chk(n == SLOT_CYC + 30, "R10 rotation stopped", n, SLOT_CYC + 30);
    exp_idx = nxt(exp_idx);
    chk(int'(cur_sta) == exp_idx, "R10 index advanced", int'(cur_sta), exp_idx);
    en = 1'b1;
    count_low(10, n);
    chk(n == 1, "R10 resume delay", n, 1);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      take_poll();
      case ($urandom % 4)
        0: sc_idle();
        1: sc_good(int'($urandom % SLOT_CYC), int'($urandom % REPLY_TO), int'($urandom % 6));
        2: begin
          foreign_src(src);
          sc_bad(int'($urandom % SLOT_CYC), int'($urandom % REPLY_TO), src);
        end
        default: sc_timeout(int'($urandom % SLOT_CYC));
      endcase
    end
    take_poll();
    finish_run();
  end
endmodule